// File: doc/BRIEF.md
# Grouped Vectored Interrupt Controller

This block gathers a wide set of interrupt lines into one interrupt request for a CPU, plus a readable vector code that names the winning line. The lines are arranged in groups of eight. Each group has four byte-wide registers on a simple synchronous byte-addressed register port: pending status, enable mask, trigger mode and polarity. Every input passes through a two-flop synchroniser. It is then qualified as a level or an edge of the selected sense and latched into its pending bit. Software clears a pending bit by writing a one to it.

The enabled pending bits drive the interrupt output. A fixed-priority scan then picks the highest-numbered enabled pending line. Its number, plus an offset of 0x10, is registered into the vector register, so back-to-back reads see the same code when nothing changes between them. A handler reads the vector, subtracts the offset, services the line and clears its pending bit.

Top module: `gvic_top`

## Requirements
- R1: The register quad of group g starts at byte address 4*g for g < 4 and at 4*g+4 for g >= 4. Inside a quad, offset 0 is status, 1 is enable, 2 is trigger mode and 3 is polarity. Bit b of the group's registers belongs to line 8*g+b. Reads of unmapped addresses (16..19, and 100..255 other than the vector address) return 0, and writes to them change nothing.
- R2: The enable, trigger-mode and polarity registers read back the last byte written to them. All of them, and all status bits, are 0 after reset.
- R3: Writing a byte to a status register clears each pending bit that has a 1 in the written byte and leaves the bits that have a 0 unchanged.
- R4: With trigger-mode bit 0 (level), the pending bit is set while the synchronised input is at its active level: high for polarity bit 0, low for polarity bit 1. If the input is still active when a clear is written, the bit is set again.
- R5: With trigger-mode bit 1 (edge), the pending bit is set by a rising edge (polarity 0) or by a falling edge (polarity 1) of the synchronised input. It then stays set until it is cleared, whatever the input does. Changing polarity or mode does not by itself produce an edge.
- R6: irq_o is high exactly when some line's pending bit and enable bit are both 1. An input change shows on irq_o within 4 clock cycles.
- R7: The vector register at byte address 0xF0 reads 0x10 plus the number of the highest-numbered line that is both pending and enabled, and reads 0x10 when there is none. Line 0 alone therefore also reads 0x10, with irq_o high.
- R8: The vector register is read-only: writes to 0xF0 change no state. A read returns data in rdata_o in the cycle after rd_en_i is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 192 | Asynchronous interrupt lines, line n on bit n |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The bench aims at the hole after group 3. A decoder that gets the stride jump wrong would alias group 4 onto those addresses or shift every upper group by one quad, and enables would read back in the wrong place. It drives line 0 on its own: a controller that treats vector 0x10 as "idle" and so drops irq_o would be caught. It also drives line 191 together with lower lines, where a scan that favours low numbers returns the wrong code. Clears are written while a level line is still active and after an edge line has gone quiet, so a design that lets set lose to clear, or that re-triggers edges from a polarity write, produces status values that differ from the bench model.

// File: rtl/gvic_pkg.sv
package gvic_pkg;

  typedef enum logic [1:0] {
    FLD_STAT = 2'd0,
    FLD_EN   = 2'd1,
    FLD_MODE = 2'd2,
    FLD_POL  = 2'd3
  } fld_e;

  typedef struct packed {
    logic        hit;
    int unsigned grp;
    fld_e        fld;
  } dec_t;

  // Map a byte address to (group, field); a gap of gap_b bytes follows the
  // first low_g groups.
  function automatic dec_t decode(int unsigned a, int unsigned ngrp,
                                  int unsigned low_g, int unsigned gap_b);
    dec_t d;
    int unsigned lin;
    d.hit = 1'b0;
    d.grp = 0;
    d.fld = fld_e'(a[1:0]);
    if (a < low_g * 4) begin
      d.hit = 1'b1;
      d.grp = a >> 2;
    end else if (a >= low_g * 4 + gap_b) begin
      lin = (a - gap_b) >> 2;
      if (lin < ngrp) begin
        d.hit = 1'b1;
        d.grp = lin;
      end
    end
    return d;
  endfunction

  function automatic logic [7:0] vec_code(logic any, int unsigned idx,
                                          int unsigned ofs);
    return any ? 8'(ofs + idx) : 8'(ofs);
  endfunction

endpackage

// File: rtl/gvic_group.sv
module gvic_group #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic         wr_stat_i,
  input  logic         wr_en_i,
  input  logic         wr_mode_i,
  input  logic         wr_pol_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] mode_o,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] pend_o
);

  logic [W-1:0] sync1_q, sync2_q, prev_q;
  logic [W-1:0] stat_q, en_q, mode_q, pol_q;
  logic [W-1:0] edge_hit, level_hit, set_evt, clr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= src_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  // Edges come from the raw synchronised input, so a polarity write alone
  // never looks like an edge.
  assign edge_hit  = mode_q & ((~pol_q & sync2_q & ~prev_q) |
                               ( pol_q & ~sync2_q & prev_q));
  assign level_hit = ~mode_q & (sync2_q ^ pol_q);
  assign set_evt   = edge_hit | level_hit;
  assign clr_req   = wr_stat_i ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      mode_q <= '0;
      pol_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_req) | set_evt;
      if (wr_en_i)   en_q   <= wdata_i;
      if (wr_mode_i) mode_q <= wdata_i;
      if (wr_pol_i)  pol_q  <= wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign pol_o  = pol_q;
  assign pend_o = stat_q & en_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stat_i && wdata_i[i] && !set_evt[i] |=> !stat_q[i]);
    p_zero_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q[i] && !clr_req[i] |=> stat_q[i]);
    p_level_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q[i] && (sync2_q[i] != pol_q[i]) |=> stat_q[i]);
    p_edge_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[i] && !pol_q[i] && sync2_q[i] && !prev_q[i] |=> stat_q[i]);
  end

endmodule

// File: rtl/gvic_prio.sv
module gvic_prio #(
  parameter int unsigned N  = 192,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pend_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);

  // Ascending scan: the last hit, i.e. the highest number, wins.
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

  p_winner_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> pend_i[idx_o]);
  p_none_above_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> ((pend_i >> idx_o) == {{(N-1){1'b0}}, 1'b1}));
  p_idle_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !any_o |-> (pend_i == '0));

endmodule

// File: rtl/gvic_top.sv
module gvic_top #(
  parameter int unsigned NUM_GROUPS = 24,
  parameter int unsigned GRP_W      = 8,
  parameter int unsigned AW         = 8,
  parameter int unsigned LOW_GROUPS = 4,
  parameter int unsigned GAP_BYTES  = 4,
  parameter int unsigned VEC_OFS    = 16,
  parameter int unsigned VEC_ADDR   = 240,
  localparam int unsigned NSRC = NUM_GROUPS * GRP_W,
  localparam int unsigned IW   = $clog2(NSRC),
  localparam int unsigned GIW  = $clog2(NUM_GROUPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [GRP_W-1:0] wdata_i,
  output logic [GRP_W-1:0] rdata_o,
  output logic             irq_o
);
  import gvic_pkg::*;

  dec_t             dec;
  logic             vec_hit;
  logic [GRP_W-1:0] stat_a [NUM_GROUPS];
  logic [GRP_W-1:0] en_a   [NUM_GROUPS];
  logic [GRP_W-1:0] mode_a [NUM_GROUPS];
  logic [GRP_W-1:0] pol_a  [NUM_GROUPS];
  logic [NSRC-1:0]  pend_flat;
  logic             any_pend;
  logic [IW-1:0]    win_idx;
  logic [7:0]       vec_q;
  logic [GRP_W-1:0] rd_d, rdata_q;

  always_comb dec = decode(32'(addr_i), NUM_GROUPS, LOW_GROUPS, GAP_BYTES);
  assign vec_hit = (addr_i == AW'(VEC_ADDR));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic sel;
    assign sel = wr_en_i && dec.hit && (dec.grp == g);
    gvic_group #(.W(GRP_W)) u_grp (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src_i[g*GRP_W +: GRP_W]),
      .wr_stat_i (sel && dec.fld == FLD_STAT),
      .wr_en_i   (sel && dec.fld == FLD_EN),
      .wr_mode_i (sel && dec.fld == FLD_MODE),
      .wr_pol_i  (sel && dec.fld == FLD_POL),
      .wdata_i   (wdata_i),
      .stat_o    (stat_a[g]),
      .en_o      (en_a[g]),
      .mode_o    (mode_a[g]),
      .pol_o     (pol_a[g]),
      .pend_o    (pend_flat[g*GRP_W +: GRP_W])
    );
  end

  gvic_prio #(.N(NSRC)) u_prio (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (pend_flat),
    .any_o  (any_pend),
    .idx_o  (win_idx)
  );

  assign irq_o = any_pend;

  always_comb begin
    rd_d = '0;
    if (vec_hit) begin
      rd_d = GRP_W'(vec_q);
    end else if (dec.hit) begin
      case (dec.fld)
        FLD_STAT: rd_d = stat_a[GIW'(dec.grp)];
        FLD_EN:   rd_d = en_a[GIW'(dec.grp)];
        FLD_MODE: rd_d = mode_a[GIW'(dec.grp)];
        default:  rd_d = pol_a[GIW'(dec.grp)];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q   <= 8'(VEC_OFS);
      rdata_q <= '0;
    end else begin
      vec_q <= vec_code(any_pend, 32'(win_idx), VEC_OFS);
      if (rd_en_i) rdata_q <= rd_d;
    end
  end

  assign rdata_o = rdata_q;

  p_idle_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |=> (vec_q == 8'(VEC_OFS)));
  p_read_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_q));
  p_vec_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_q >= 8'(VEC_OFS)) && (vec_q < 8'(VEC_OFS + NSRC)));

endmodule

// File: tb/tb_gvic_top.sv
module tb_gvic_top;
  localparam int NG = 24;
  localparam int NS = NG * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [7:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  bit [7:0] m_stat [NG];
  bit [7:0] m_en   [NG];
  bit [7:0] m_mode [NG];
  bit [7:0] m_pol  [NG];

  always #5 clk = ~clk;

  gvic_top dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic int reg_addr(int g, int f);
    int base = (g > 3) ? g * 4 + 4 : g * 4;
    return base + f;
  endfunction

  function automatic int exp_vec();
    for (int g = NG - 1; g >= 0; g--)
      for (int b = 7; b >= 0; b--)
        if (m_stat[g][b] && m_en[g][b]) return 16 + g * 8 + b;
    return 16;
  endfunction

  function automatic bit exp_irq();
    for (int g = 0; g < NG; g++)
      if ((m_stat[g] & m_en[g]) != 0) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int exp_reg(int a);
    if (a == 240) return exp_vec();
    for (int g = 0; g < NG; g++)
      for (int f = 0; f < 4; f++)
        if (reg_addr(g, f) == a)
          case (f)
            0: return m_stat[g];
            1: return m_en[g];
            2: return m_mode[g];
            default: return m_pol[g];
          endcase
    return 0;
  endfunction

  task automatic level_fill();
    for (int s = 0; s < NS; s++)
      if (!m_mode[s/8][s%8] && (src[s] != m_pol[s/8][s%8]))
        m_stat[s/8][s%8] = 1'b1;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'(a); wdata = 8'(d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    // model
    for (int g = 0; g < NG; g++) begin
      if (reg_addr(g, 0) == a) m_stat[g] &= ~8'(d);
      if (reg_addr(g, 1) == a) m_en[g] = 8'(d);
      if (reg_addr(g, 2) == a) m_mode[g] = 8'(d);
      if (reg_addr(g, 3) == a) m_pol[g] = 8'(d);
    end
    level_fill();
    settle();
  endtask

  task automatic bus_rd(int a, output int d);
    @(negedge clk);
    rd_en = 1'b1; addr = 8'(a);
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic drive(logic [NS-1:0] nv);
    @(negedge clk);
    for (int s = 0; s < NS; s++)
      if (m_mode[s/8][s%8]) begin
        if (!m_pol[s/8][s%8] && !src[s] && nv[s]) m_stat[s/8][s%8] = 1'b1;
        if ( m_pol[s/8][s%8] && src[s] && !nv[s]) m_stat[s/8][s%8] = 1'b1;
      end
    src = nv;
    level_fill();
    settle();
  endtask

  task automatic check_reg(string req, int a);
    int d;
    bus_rd(a, d);
    check(req, d, exp_reg(a));
  endtask

  task automatic check_out(string req);
    int d;
    check({req, " irq"}, int'(irq), int'(exp_irq()));
    bus_rd(240, d);
    check({req, " vector"}, d, exp_vec());
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int d;
    logic [NS-1:0] nv;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    settle();

    // Reset state: R2, R6, R7
    check("R6 reset irq", int'(irq), 0);
    check_reg("R2 reset enable g0", reg_addr(0, 1));
    check_reg("R2 reset polarity g23", reg_addr(23, 3));
    check_reg("R7 reset vector", 240);

    // Line 0 alone: vector equals idle code, irq high (R7, R6, R4)
    bus_wr(reg_addr(0, 1), 8'h01);
    nv = src; nv[0] = 1'b1; drive(nv);
    check("R6 line0 irq", int'(irq), 1);
    check_reg("R7 line0 vector", 240);
    check_reg("R4 line0 status", reg_addr(0, 0));

    // Highest line wins (R7), address after gap (R1)
    bus_wr(reg_addr(23, 1), 8'h80);
    nv = src; nv[191] = 1'b1; drive(nv);
    check_reg("R7 line191 vector", 240);
    check("R7 line191 value", exp_vec(), 16 + 191);

    // Level re-set after clear while active (R4), clear takes when inactive (R3)
    bus_wr(reg_addr(23, 0), 8'h80);
    check_reg("R4 level re-set", reg_addr(23, 0));
    nv = src; nv[191] = 1'b0; drive(nv);
    bus_wr(reg_addr(23, 0), 8'h80);
    check_reg("R3 w1c clear", reg_addr(23, 0));
    check_out("R7 after clear");

    // Hole and unmapped addresses (R1), vector write ignored (R8)
    bus_wr(reg_addr(3, 1), 8'h5A);
    bus_wr(reg_addr(4, 1), 8'hA5);
    for (int a = 16; a < 20; a++) bus_wr(a, 8'hFF);
    bus_wr(240, 8'hC3);
    check_reg("R1 g3 enable", reg_addr(3, 1));
    check_reg("R1 g4 enable", reg_addr(4, 1));
    for (int a = 16; a < 20; a++) check_reg("R1 hole read", a);
    check_reg("R1 unmapped read", 100);
    check_reg("R8 vector after write", 240);

    // Edge mode, falling sense, stays after input returns (R5)
    bus_wr(reg_addr(10, 2), 8'h04);
    bus_wr(reg_addr(10, 3), 8'h04);
    bus_wr(reg_addr(10, 1), 8'h04);
    check_reg("R5 no edge from config", reg_addr(10, 0));
    nv = src; nv[82] = 1'b1; drive(nv);
    nv = src; nv[82] = 1'b0; drive(nv);
    nv = src; nv[82] = 1'b1; drive(nv);
    check_reg("R5 falling edge latched", reg_addr(10, 0));
    check_out("R5 edge vector");

    // Constrained random phase
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 9);
      int g = $urandom_range(0, NG - 1);
      if (op < 3) begin
        bus_wr(reg_addr(g, $urandom_range(1, 3)), $urandom_range(0, 255));
      end else if (op < 5) begin
        bus_wr(reg_addr(g, 0), $urandom_range(0, 255));
      end else if (op < 8) begin
        nv = src;
        for (int k = 0; k < 3; k++) nv[$urandom_range(0, NS - 1)] ^= 1'b1;
        drive(nv);
      end else begin
        bus_wr($urandom_range(0, 255), $urandom_range(0, 255));
      end
      check_out("R6 R7 random");
      if (it % 3 == 0) check_reg("R2 R3 R4 R5 random reg", $urandom_range(0, 120));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule